// File: doc/BRIEF.md
# I2C Bus Start/Stop Watcher

This block watches the two wires of an I2C bus and tells the rest of the controller whether the bus is in use. It first brings both lines into the system clock domain through a flop chain. It then finds start conditions (data falling while the clock line is high) and stop conditions (data rising while the clock line is high). From these it keeps a busy flag, and a flag that says the local controller is taking part in the current transfer.

Two policies apply when the block is switched on. A configuration bit chooses how the busy flag starts out when the enable goes high. If the bit is clear, the bus is treated as occupied until the first stop is seen. If it is set, the bus is treated as free straight away. If the lines already show clock high and data low at the moment of enabling, a start is reported on that same edge. That configuration bit is written through a write strobe, and the write only takes effect while the block is disabled.

A local-release strobe drops the block out of the transfer it has joined, so it does not acknowledge anything in that transfer. A stop interrupt request copies the stop pulse only while its own enable input is high.

Top module: `i2c_bus_watch`

## Requirements
- R1: While `en` is 0, the registered outputs `busy`, `participating`, `start_pulse`, `stop_pulse` and `stop_irq` are all 0 from the clock edge after `en` is sampled low. After reset they are all 0.
- R2: A start condition raises `start_pulse` for exactly one cycle. A start condition is sampled data going 1 to 0 while sampled clock is 1 in both samples. On the same edge, `busy` and `participating` become 1.
- R3: A stop condition raises `stop_pulse` for exactly one cycle. A stop condition is sampled data going 0 to 1 while sampled clock is 1 in both samples. On the same edge, `busy` and `participating` become 0.
- R4: On the first enabled edge (`en` 1, previous `en` 0) with the stored free-at-enable bit equal to 0, `busy` becomes 1 whatever the line levels are. It stays 1 until a stop condition.
- R5: On the first enabled edge with the stored free-at-enable bit equal to 1, `busy` becomes 0, unless R6 reports a start on that edge.
- R6: If the synchronized clock is 1 and the synchronized data is 0 on the first enabled edge, `start_pulse`, `busy` and `participating` become 1 on that edge.
- R7: `stop_irq` is 1 exactly when `stop_pulse` is 1 and `stop_irq_en` was 1 at that edge. With `stop_irq_en` at 0 it stays 0.
- R8: `local_release` at 1 on an enabled edge clears `participating` and leaves `busy` unchanged. `participating` stays 0 until the next start. A start on the same edge takes priority.
- R9: A `cfg_wr` pulse stores `cfg_free_wdata` into the free-at-enable bit only while `en` is 0. A write made while enabled is dropped, and the next enable follows the old value.
- R10: With two synchronizer stages, a line change driven before clock edge k appears in `start_pulse` or `stop_pulse` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw I2C clock line level |
| sda_in | input | 1 | Raw I2C data line level |
| en | input | 1 | Block enable |
| cfg_wr | input | 1 | Write strobe for the free-at-enable bit |
| cfg_free_wdata | input | 1 | Value written to the free-at-enable bit |
| stop_irq_en | input | 1 | Enable for the stop interrupt request |
| local_release | input | 1 | Strobe that drops out of the current transfer |
| start_pulse | output | 1 | One-cycle start-detected pulse |
| stop_pulse | output | 1 | One-cycle stop-detected pulse |
| busy | output | 1 | Bus busy flag |
| stop_irq | output | 1 | Gated stop interrupt request |
| participating | output | 1 | Local controller takes part in the current transfer |

## Verification
A change on the raw lines passes two synchronizer flops and then one output register. The resulting pulse and flag change is therefore visible in the low clock phase after the third rising edge that follows the change. `en`, `local_release` and `stop_irq_en` act on the registered outputs at the very next edge. A configuration write is seen only at the next enable edge. The bench drives all inputs on falling edges. Its reference model keeps a short queue of past line samples to reproduce the three-edge delay, and compares every output at each falling edge. The directed checks wait exactly those edge counts before they sample.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

  localparam int unsigned LINE_W = $bits(bus_lines_t);
  localparam bus_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned W = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] pipe [DEPTH];

  // stage 0 samples the pin; the extra last stage keeps one cycle of history
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= RST_VAL;
          else     pipe[i] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= RST_VAL;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign cur = pipe[STAGES-1];
  assign prv = pipe[STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_watch_pkg::*;
(
  input  bus_lines_t cur,
  input  bus_lines_t prv,
  output logic       start_det,
  output logic       stop_det
);
  logic clk_high;

  always_comb begin
    clk_high  = cur.scl & prv.scl;
    start_det = clk_high & prv.sda & ~cur.sda;
    stop_det  = clk_high & ~prv.sda & cur.sda;
  end
endmodule

// File: rtl/i2c_bus_state.sv
module i2c_bus_state
  import i2c_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       cfg_wr,
  input  logic       cfg_free_wdata,
  input  logic       stop_irq_en,
  input  logic       local_release,
  input  bus_lines_t cur,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic       busy,
  output logic       stop_irq,
  output logic       participating
);
  logic cfg_free_q;
  logic en_q;
  logic en_rise;
  logic en_start;

  always_comb begin
    en_rise  = en & ~en_q;
    en_start = en_rise & cur.scl & ~cur.sda;
  end

  // configuration is only writable while the block is off
  always_ff @(posedge clk) begin
    if (rst)                cfg_free_q <= 1'b0;
    else if (cfg_wr && !en) cfg_free_q <= cfg_free_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      start_pulse   <= 1'b0;
      stop_pulse    <= 1'b0;
      busy          <= 1'b0;
      stop_irq      <= 1'b0;
      participating <= 1'b0;
    end else if (en_rise) begin
      start_pulse   <= en_start;
      stop_pulse    <= 1'b0;
      busy          <= en_start | ~cfg_free_q;
      stop_irq      <= 1'b0;
      participating <= en_start;
    end else begin
      start_pulse <= start_det;
      stop_pulse  <= stop_det;
      stop_irq    <= stop_det & stop_irq_en;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
      if (start_det)                      participating <= 1'b1;
      else if (stop_det || local_release) participating <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2c_watch_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic en,
  input  logic cfg_wr,
  input  logic cfg_free_wdata,
  input  logic stop_irq_en,
  input  logic local_release,
  output logic start_pulse,
  output logic stop_pulse,
  output logic busy,
  output logic stop_irq,
  output logic participating
);
  bus_lines_t raw_lines;
  bus_lines_t cur_lines;
  bus_lines_t prv_lines;
  logic       start_det;
  logic       stop_det;

  assign raw_lines = '{scl: scl_in, sda: sda_in};

  i2c_line_sync #(
    .W      (LINE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .raw(raw_lines),
    .cur(cur_lines),
    .prv(prv_lines)
  );

  i2c_cond_detect u_det (
    .cur      (cur_lines),
    .prv      (prv_lines),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_bus_state u_state (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .cfg_wr        (cfg_wr),
    .cfg_free_wdata(cfg_free_wdata),
    .stop_irq_en   (stop_irq_en),
    .local_release (local_release),
    .cur           (cur_lines),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .start_pulse   (start_pulse),
    .stop_pulse    (stop_pulse),
    .busy          (busy),
    .stop_irq      (stop_irq),
    .participating (participating)
  );
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic stop_irq_en,
  input logic local_release,
  input logic start_pulse,
  input logic stop_pulse,
  input logic busy,
  input logic stop_irq,
  input logic participating
);
  p_quiet_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && !participating && !start_pulse && !stop_pulse && !stop_irq));

  p_start_flags_r2: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (busy && participating));

  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  p_stop_flags_r3: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> (!busy && !participating));

  p_stop_single_r3: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  p_irq_needs_stop_r7: assert property (@(posedge clk) disable iff (rst)
    stop_irq |-> stop_pulse);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !stop_irq_en |=> !stop_irq);

  p_join_on_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(participating) |-> start_pulse);

  p_release_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (en && local_release && participating) |=> (!participating || start_pulse));

  p_no_both_r2: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && stop_pulse));
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .stop_irq_en  (stop_irq_en),
  .local_release(local_release),
  .start_pulse  (start_pulse),
  .stop_pulse   (stop_pulse),
  .busy         (busy),
  .stop_irq     (stop_irq),
  .participating(participating)
);

// File: tb/tb_i2c_bus_watch.sv
`timescale 1ns/1ps
module tb_i2c_bus_watch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1, sda_in = 1'b1, en = 1'b0, cfg_wr = 1'b0, cfg_free_wdata = 1'b0;
  logic stop_irq_en = 1'b0, local_release = 1'b0;
  logic start_pulse, stop_pulse, busy, stop_irq, participating;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_watch dut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .en(en),
    .cfg_wr(cfg_wr), .cfg_free_wdata(cfg_free_wdata), .stop_irq_en(stop_irq_en),
    .local_release(local_release), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .busy(busy), .stop_irq(stop_irq), .participating(participating)
  );

  // behavioural reference: queue of past {scl,sda} samples, newest first
  logic [1:0] hist[$];
  bit m_cfg, m_en_prev, m_start, m_stop, m_busy, m_irq, m_part;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_cfg = 0; m_en_prev = 0;
      m_start = 0; m_stop = 0; m_busy = 0; m_irq = 0; m_part = 0;
    end else begin
      bit now_scl, now_sda, old_scl, old_sda, fall, rise, edge_on;
      now_scl = hist[1][1]; now_sda = hist[1][0];
      old_scl = hist[2][1]; old_sda = hist[2][0];
      fall = now_scl && old_scl && old_sda && !now_sda;
      rise = now_scl && old_scl && !old_sda && now_sda;
      edge_on = en && !m_en_prev;
      if (!en) begin
        m_start = 0; m_stop = 0; m_busy = 0; m_irq = 0; m_part = 0;
      end else if (edge_on) begin
        m_start = now_scl && !now_sda;
        m_stop = 0; m_irq = 0;
        m_busy = m_start || !m_cfg;
        m_part = m_start;
      end else begin
        m_start = fall; m_stop = rise; m_irq = rise && stop_irq_en;
        if (fall) m_busy = 1; else if (rise) m_busy = 0;
        if (fall) m_part = 1; else if (rise || local_release) m_part = 0;
      end
      if (cfg_wr && !en) m_cfg = cfg_free_wdata;
      m_en_prev = en;
      hist.push_front({scl_in, sda_in});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model each low phase
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(start_pulse === m_start, "R2 start_pulse vs model", start_pulse, m_start);
      chk(stop_pulse === m_stop, "R3 stop_pulse vs model", stop_pulse, m_stop);
      chk(busy === m_busy, "R4 busy vs model", busy, m_busy);
      chk(stop_irq === m_irq, "R7 stop_irq vs model", stop_irq, m_irq);
      chk(participating === m_part, "R8 participating vs model", participating, m_part);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start();
    sda_in = 1'b0; tick(3);
  endtask

  task automatic do_stop();
    sda_in = 1'b1; tick(3);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    chk({busy, participating, start_pulse, stop_pulse, stop_irq} == 5'b0, "R1 reset flags",
        {busy, participating, start_pulse, stop_pulse, stop_irq}, 0);

    // R4: enable with free bit 0 on an idle bus
    en = 1'b1; tick(1);
    chk(busy === 1'b1, "R4 busy at enable", busy, 1);
    chk(start_pulse === 1'b0, "R6 no start on idle enable", start_pulse, 0);
    tick(5);
    chk(busy === 1'b1, "R4 busy held", busy, 1);

    // R3/R7/R10: stop with irq enabled (data low first, while clock low)
    scl_in = 1'b0; tick(1); sda_in = 1'b0; tick(1); scl_in = 1'b1; tick(4);
    stop_irq_en = 1'b1;
    sda_in = 1'b1; tick(2);
    chk(stop_pulse === 1'b0, "R10 stop not before third edge", stop_pulse, 0);
    tick(1);
    chk(stop_pulse === 1'b1, "R10 stop on third edge", stop_pulse, 1);
    chk(stop_irq === 1'b1, "R7 irq with enable", stop_irq, 1);
    chk(busy === 1'b0, "R3 busy cleared", busy, 0);
    tick(1);
    chk(stop_pulse === 1'b0, "R3 single pulse", stop_pulse, 0);

    // R2: start
    do_start();
    chk(start_pulse === 1'b1, "R2 start pulse", start_pulse, 1);
    chk(busy && participating, "R2 flags set", {busy, participating}, 3);
    tick(1);

    // R8: local release
    local_release = 1'b1; tick(1); local_release = 1'b0;
    chk(participating === 1'b0, "R8 dropped", participating, 0);
    chk(busy === 1'b1, "R8 busy kept", busy, 1);
    // data toggling with clock low is not a start
    scl_in = 1'b0; tick(1); sda_in = 1'b1; tick(1); sda_in = 1'b0; tick(4);
    chk(participating === 1'b0, "R8 stays out", participating, 0);

    // R7: stop with irq disabled
    scl_in = 1'b1; tick(3);
    stop_irq_en = 1'b0;
    do_stop();
    chk(stop_pulse === 1'b1, "R3 stop seen", stop_pulse, 1);
    chk(stop_irq === 1'b0, "R7 irq suppressed", stop_irq, 0);

    // R9: write while enabled is dropped
    cfg_wr = 1'b1; cfg_free_wdata = 1'b1; tick(1); cfg_wr = 1'b0;
    en = 1'b0; tick(1);
    chk({busy, participating} == 2'b0, "R1 cleared when off", {busy, participating}, 0);
    en = 1'b1; tick(1);
    chk(busy === 1'b1, "R9 write while on ignored", busy, 1);

    // R5: write while disabled takes effect
    en = 1'b0; tick(1);
    cfg_wr = 1'b1; cfg_free_wdata = 1'b1; tick(1); cfg_wr = 1'b0;
    en = 1'b1; tick(1);
    chk(busy === 1'b0, "R5 free at enable", busy, 0);

    // R6: enable while the lines already look like a start
    en = 1'b0; tick(1);
    sda_in = 1'b0; tick(3);
    en = 1'b1; tick(1);
    chk(start_pulse === 1'b1, "R6 start at enable", start_pulse, 1);
    chk(busy && participating, "R6 flags", {busy, participating}, 3);
    tick(1);

    // R8: start beats release on the same edge
    do_stop();
    sda_in = 1'b0; tick(2); local_release = 1'b1; tick(1); local_release = 1'b0;
    chk(participating === 1'b1, "R8 start wins over release", participating, 1);
    tick(2);
    en = 1'b0; tick(2);
    chk({busy, participating, stop_irq} == 3'b0, "R1 off again", {busy, participating, stop_irq}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule